// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block turns the opcode of an instruction in the decode stage of a five-stage load/store pipeline into nine control bits. It covers four instruction kinds: register-to-register arithmetic, load word, store word and branch-if-equal. The nine bits are split into three groups, one for each stage that uses them. The execute group selects the destination field, the ALU operation class and the second ALU operand. The memory group covers branch, memory read and memory write. The writeback group covers register write and the choice between the memory result and the ALU result.

The full bundle is registered at the end of decode. Each later stage register keeps only the groups still needed downstream, so the carried width goes from nine bits to five and then to two. A bubble request zeroes the bundle as it enters the first stage register. This turns the slot into a no-operation that changes neither memory nor the register file. The execute, memory and writeback logic each read their own group at the matching output. Decoding the ALU function field, detecting hazards and building the datapath are left to neighbouring blocks.

Top module: `pipe_ctl_decoder`

## Requirements
- R1: While reset is asserted, `ex_o`, `mem_o` and `wb_o` are all zero, whatever opcode is presented.
- R2: Opcode 0 (register format) yields `ex_o` = 4'b1100, where `ex_o` = {dest_is_rd, aluop[1], aluop[0], operand_is_imm}. It then yields `mem_o` = 3'b000, where `mem_o` = {branch, mem_read, mem_write}, and `wb_o` = 2'b10, where `wb_o` = {reg_write, result_from_mem}.
- R3: Opcode 35 (load) yields `ex_o` = 4'b0001, `mem_o` = 3'b010 and `wb_o` = 2'b11, with the field order of R2.
- R4: Opcode 43 (store) yields `ex_o` = 4'b0001, `mem_o` = 3'b001 and `wb_o` = 2'b00. Its don't-care bits are driven to 0.
- R5: Opcode 4 (branch-if-equal) yields `ex_o` = 4'b0010, `mem_o` = 3'b100 and `wb_o` = 2'b00.
- R6: Any other opcode yields zero in all three groups.
- R7: When `bubble_i` is high, the bundle captured for that slot is all zero. Its `ex_o`, `mem_o` and `wb_o` values are all zero, whatever the opcode.
- R8: An opcode sampled at a rising edge appears on `ex_o` after that edge. Its memory group appears on `mem_o` one edge later, and its writeback group appears on `wb_o` two edges later. Back-to-back instructions do not disturb each other's groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 6 | Opcode of the instruction in decode |
| bubble_i | input | 1 | Forces a zero bundle into the decode/execute register |
| ex_o | output | 4 | Execute group from the decode/execute register |
| mem_o | output | 3 | Memory group from the execute/memory register |
| wb_o | output | 2 | Writeback group from the memory/writeback register |

## Verification
The bench uses the default 6-bit opcode width and the default opcode assignments. At that width, every one of the 64 opcodes can be swept with the bubble both low and high. Each of these slots is followed through all three stage registers. A second run sends a dense mix of the four known opcodes, unknown opcodes and scattered bubbles, one per cycle. This run shows that the groups of neighbouring instructions stay apart in every stage register.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int unsigned OP_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE = 6'd43;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;

  typedef struct packed {
    logic       dest_rd;
    logic [1:0] alu_cls;
    logic       opnd_imm;
  } ex_ctl_t;

  typedef struct packed {
    logic br;
    logic mrd;
    logic mwr;
  } mem_ctl_t;

  typedef struct packed {
    logic rwr;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_bundle_t;

  localparam int unsigned EX_W  = $bits(ex_ctl_t);
  localparam int unsigned MEM_W = $bits(mem_ctl_t);
  localparam int unsigned WB_W  = $bits(wb_ctl_t);
  localparam int unsigned ALL_W = $bits(ctl_bundle_t);

endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter logic [OP_W-1:0] RTYPE_OP = OPC_RTYPE,
  parameter logic [OP_W-1:0] LOAD_OP  = OPC_LOAD,
  parameter logic [OP_W-1:0] STORE_OP = OPC_STORE,
  parameter logic [OP_W-1:0] BEQ_OP   = OPC_BEQ
) (
  input  logic [OP_W-1:0] op,
  input  logic            kill,
  output ctl_bundle_t     bundle
);
  ctl_bundle_t raw;

  always_comb begin
    raw = '0;
    case (op)
      RTYPE_OP: begin
        raw.ex.dest_rd = 1'b1;
        raw.ex.alu_cls = 2'b10;
        raw.wb.rwr     = 1'b1;
      end
      LOAD_OP: begin
        raw.ex.opnd_imm = 1'b1;
        raw.mem.mrd     = 1'b1;
        raw.wb.rwr      = 1'b1;
        raw.wb.from_mem = 1'b1;
      end
      STORE_OP: begin
        raw.ex.opnd_imm = 1'b1;
        raw.mem.mwr     = 1'b1;
      end
      BEQ_OP: begin
        raw.ex.alu_cls = 2'b01;
        raw.mem.br     = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  always_comb begin
    bundle = kill ? '0 : raw;
  end
endmodule

// File: rtl/ctl_stage.sv
module ctl_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pipe_ctl_decoder.sv
module pipe_ctl_decoder
  import ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      op_i,
  input  logic            bubble_i,
  output logic [3:0]      ex_o,
  output logic [2:0]      mem_o,
  output logic [1:0]      wb_o
);
  localparam int unsigned EM_W = MEM_W + WB_W;

  logic        srst_n;
  ctl_bundle_t dec_bundle;
  logic [ALL_W-1:0] de_q;
  logic [EM_W-1:0]  em_d;
  logic [EM_W-1:0]  em_q;
  logic [WB_W-1:0]  mw_d;
  logic [WB_W-1:0]  mw_q;
  ctl_bundle_t de_view;

  ctl_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ctl_decode i_decode (
    .op     (op_i),
    .kill   (bubble_i),
    .bundle (dec_bundle)
  );

  ctl_stage #(.W(ALL_W)) i_de_stage (
    .clk   (clk),
    .rst_n (srst_n),
    .ld    (1'b1),
    .d     (dec_bundle),
    .q     (de_q)
  );

  always_comb begin
    de_view = ctl_bundle_t'(de_q);
    em_d    = {de_view.mem, de_view.wb};
  end

  ctl_stage #(.W(EM_W)) i_em_stage (
    .clk   (clk),
    .rst_n (srst_n),
    .ld    (1'b1),
    .d     (em_d),
    .q     (em_q)
  );

  always_comb begin
    mw_d = em_q[WB_W-1:0];
  end

  ctl_stage #(.W(WB_W)) i_mw_stage (
    .clk   (clk),
    .rst_n (srst_n),
    .ld    (1'b1),
    .d     (mw_d),
    .q     (mw_q)
  );

  assign ex_o  = de_view.ex;
  assign mem_o = em_q[EM_W-1:WB_W];
  assign wb_o  = mw_q;
endmodule

// File: rtl/pipe_ctl_decoder_chk.sv
module pipe_ctl_decoder_chk
  import ctl_pkg::*;
(
  input logic       clk,
  input logic       srst_n,
  input logic [5:0] op_i,
  input logic       bubble_i,
  input logic [3:0] ex_o,
  input logic [2:0] mem_o,
  input logic [1:0] wb_o
);
  // R2
  rtype_ex_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i == OPC_RTYPE && !bubble_i) |=> (ex_o == 4'b1100));

  // R3
  load_flow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i == OPC_LOAD && !bubble_i) |=> (ex_o == 4'b0001) ##1 (mem_o == 3'b010) ##1 (wb_o == 2'b11));

  // R4
  store_ex_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i == OPC_STORE && !bubble_i) |=> (ex_o == 4'b0001) ##1 (mem_o == 3'b001));

  // R5
  beq_ex_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i == OPC_BEQ && !bubble_i) |=> (ex_o == 4'b0010) ##1 (mem_o == 3'b100) ##1 (wb_o == 2'b00));

  // R6
  unknown_op_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i != OPC_RTYPE && op_i != OPC_LOAD && op_i != OPC_STORE && op_i != OPC_BEQ)
      |=> (ex_o == 4'b0000));

  // R7
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bubble_i |=> (ex_o == 4'b0000) ##1 (mem_o == 3'b000) ##1 (wb_o == 2'b00));

  // R8
  rtype_wb_lat_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (op_i == OPC_RTYPE && !bubble_i) |=> ##2 (wb_o == 2'b10));
endmodule

bind pipe_ctl_decoder pipe_ctl_decoder_chk i_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .op_i     (op_i),
  .bubble_i (bubble_i),
  .ex_o     (ex_o),
  .mem_o    (mem_o),
  .wb_o     (wb_o)
);

// File: tb/test_pipe_ctl_decoder.sv
module test_pipe_ctl_decoder;
  logic       clk;
  logic       rst_n;
  logic [5:0] op_i;
  logic       bubble_i;
  logic [3:0] ex_o;
  logic [2:0] mem_o;
  logic [1:0] wb_o;

  int n_cmp;
  int n_bad;
  bit done;

  logic [8:0] e1, e2, e3;

  pipe_ctl_decoder i_pipe_ctl_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .bubble_i (bubble_i),
    .ex_o     (ex_o),
    .mem_o    (mem_o),
    .wb_o     (wb_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bundle layout {ex[3:0], mem[2:0], wb[1:0]}
  function automatic logic [8:0] model(input logic [5:0] op, input logic bub);
    if (bub) return 9'd0;
    case (op)
      6'd0:    return {4'b1100, 3'b000, 2'b10};
      6'd35:   return {4'b0001, 3'b010, 2'b11};
      6'd43:   return {4'b0001, 3'b001, 2'b00};
      6'd4:    return {4'b0010, 3'b100, 2'b00};
      default: return 9'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic bub);
    if (bub) return "R7";
    case (op)
      6'd0:    return "R2";
      6'd35:   return "R3";
      6'd43:   return "R4";
      6'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  string t1, t2, t3;

  // called at a falling edge: check outputs, then drive the next slot
  task automatic step(input logic [5:0] op, input logic bub);
    check(t1, "ex_o", int'(ex_o), int'(e1[8:5]));
    check({"R8/", t2}, "mem_o", int'(mem_o), int'(e2[4:2]));
    check({"R8/", t3}, "wb_o", int'(wb_o), int'(e3[1:0]));
    op_i     = op;
    bubble_i = bub;
    e3 = e2; t3 = t2;
    e2 = e1; t2 = t1;
    e1 = model(op, bub);
    t1 = tag_of(op, bub);
    @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    e1 = '0; e2 = '0; e3 = '0;
    t1 = "R6"; t2 = "R6"; t3 = "R6";
    rst_n = 1'b0;
    op_i = 6'd0;
    bubble_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state with a valid opcode presented
    for (int k = 0; k < 3; k++) begin
      check("R1", "ex_o", int'(ex_o), 0);
      check("R1", "mem_o", int'(mem_o), 0);
      check("R1", "wb_o", int'(wb_o), 0);
      op_i = (k == 1) ? 6'd35 : 6'd0;
      @(negedge clk);
    end
    op_i = 6'h3F;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // exhaustive sweep over opcodes and bubble
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 64; o++)
        step(6'(o), 1'(b));
    // dense mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [5:0] op;
      case ((i * 5 + i / 3) % 6)
        0: op = 6'd0;
        1: op = 6'd35;
        2: op = 6'd43;
        3: op = 6'd4;
        4: op = 6'((i * 13) % 64);
        default: op = 6'd35;
      endcase
      step(op, (i % 7) == 3);
    end
    repeat (3) step(6'h3F, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule